// File: doc/BRIEF.md
# CAN Controller Interrupt Control

This block sits between a CAN protocol engine and the CPU and decides when the controller raises its single interrupt request. It holds three enable bits: a master enable, a status-change enable and an error-status enable. From the protocol engine it takes one-cycle strobes for a good transmission, a good reception and a detected bus error. It also takes the bus-off and error-warning levels, and it finds a change in either one by comparing each level with its value on the previous clock. A status-change pending flag and an error-status pending flag hold these sources until the CPU reads the status register, and that read clears both flags.

Message objects send in one pending bit each from the transmit-completion path. When an object reports that its transmission is done, its pending bit is set only if that object's transmit interrupt enable is high. The CPU reads an identifier that names the lowest-numbered object that is pending. It clears an object by writing that object's identifier back. The interrupt line is registered. It is the master enable ANDed with the OR of all pending sources, so it stays high until every source has been serviced.

Top module: `can_irq_ctrl`

## Requirements
- R1: After reset the interrupt output is low, all enables and pending flags are clear, and the control, status and object registers all read 0 while the bus-off and warning inputs are low.
- R2: A write to register select 0 stores data bit 1 as the master enable, bit 2 as the status-change enable and bit 3 as the error enable. A read of select 0 returns those bits in the same positions. All other bits read 0, and the values written to them have no effect, so bit 4 is kept reserved.
- R3: When the status-change enable is set, a transmit-ok, receive-ok or bus-error strobe sets the status-change pending flag (status bit 0) at the next clock edge. When that enable is clear, these strobes do not set the flag.
- R4: When the error enable is set, a rise or a fall of the bus-off input or of the warning input, compared with its value on the previous clock, sets the error pending flag (status bit 1). A level that stays steady does not set it, and nothing sets it while the error enable is clear.
- R5: A read of select 1 returns these status bits: bit 0 status-change pending, bit 1 error pending, bit 2 transmit-ok seen, bit 3 receive-ok seen, bit 4 bus error seen, bit 5 zero, bit 6 the warning input, bit 7 the bus-off input. The read clears bits 0 to 4 at its clock edge. An event that arrives in the same cycle as the read leaves its bit set.
- R6: A transmit-done strobe for object i sets pending bit i only while that object's transmit interrupt enable is high. Writing the value i+1 to select 2 clears pending bit i. A write of 0 or of any value above the object count has no effect. If a set and a clear of the same object arrive in the same cycle, the set wins.
- R7: A read of select 2 returns i+1, where i is the lowest-numbered pending object, or 0 when no object is pending.
- R8: The interrupt output is a register that is loaded on every edge with the master enable ANDed with the OR of status-change pending, error pending and every object pending bit. It stays high while any source is pending and goes low one edge after the master enable is cleared. Clearing the master enable leaves the pending flags unchanged.
- R9: Register select 3 reads 0, and a write to it has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (the status read clears flags) |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 object id, 3 unused |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register (combinational) |
| ev_tx_ok | input | 1 | Strobe: a transmission completed |
| ev_rx_ok | input | 1 | Strobe: a reception completed |
| ev_bus_err | input | 1 | Strobe: a bus error was detected |
| st_boff | input | 1 | Bus-off status level |
| st_ewarn | input | 1 | Error-warning status level |
| obj_tx_done | input | NOBJ | Per-object transmit-done strobes |
| obj_txie | input | NOBJ | Per-object transmit interrupt enables |
| irq_o | output | 1 | Registered module interrupt request |

## Verification
The bench builds the block with the default of four message objects. With that size every object index can be set and cleared one at a time, and the lowest-first identifier order can be walked through the whole pending set. All 256 control-register write values are swept, and so are all 256 object-clear codes, so every code outside the valid range is shown to have no effect. The status-change strobes and the edges of both status levels are each tried with the matching enable set and clear, and the same-cycle collisions of a set with a clear are exercised for the status flags and for the object bits.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;

  localparam int REG_W = 8;

  // register select codes
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_OBJ  = 2'd2;

  // control register bit positions
  localparam int CTL_MIE = 1;
  localparam int CTL_SIE = 2;
  localparam int CTL_EIE = 3;

  typedef struct packed {
    logic eie;
    logic sie;
    logic mie;
  } ctl_t;

  // request equation shared by the request stage
  function automatic logic req_merge(input logic mie, input logic stat,
                                     input logic err, input logic obj_any);
    return mie & (stat | err | obj_any);
  endfunction

  // a held flag that is set by an event and dropped by a clear; set wins
  function automatic logic hold_flag(input logic cur, input logic set,
                                     input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/can_irq_ctlreg.sv
module can_irq_ctlreg
  import can_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [3:1]       wbits,
  output ctl_t             ctl_o,
  output logic [REG_W-1:0] rd_val
);

  ctl_t ctl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (wr_en) begin
      ctl_q.mie <= wbits[CTL_MIE];
      ctl_q.sie <= wbits[CTL_SIE];
      ctl_q.eie <= wbits[CTL_EIE];
    end
  end

  always_comb begin
    rd_val          = '0;
    rd_val[CTL_MIE] = ctl_q.mie;
    rd_val[CTL_SIE] = ctl_q.sie;
    rd_val[CTL_EIE] = ctl_q.eie;
  end

  assign ctl_o = ctl_q;

endmodule

// File: rtl/can_irq_evtrk.sv
module can_irq_evtrk
  import can_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sie,
  input  logic             eie,
  input  logic             ev_tx,
  input  logic             ev_rx,
  input  logic             ev_err,
  input  logic             boff,
  input  logic             ewarn,
  input  logic             rd_clr,
  output logic             stat_pend,
  output logic             err_pend,
  output logic             boff_chg,
  output logic             ewarn_chg,
  output logic [REG_W-1:0] rd_val
);

  logic boff_q, ewarn_q;
  logic seen_tx, seen_rx, seen_err;
  logic stat_set, err_set;

  // previous-cycle copies for edge detection
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      boff_q  <= 1'b0;
      ewarn_q <= 1'b0;
    end else begin
      boff_q  <= boff;
      ewarn_q <= ewarn;
    end
  end

  assign boff_chg  = boff ^ boff_q;
  assign ewarn_chg = ewarn ^ ewarn_q;
  assign stat_set  = sie & (ev_tx | ev_rx | ev_err);
  assign err_set   = eie & (boff_chg | ewarn_chg);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_pend <= 1'b0;
      err_pend  <= 1'b0;
      seen_tx   <= 1'b0;
      seen_rx   <= 1'b0;
      seen_err  <= 1'b0;
    end else begin
      stat_pend <= hold_flag(stat_pend, stat_set, rd_clr);
      err_pend  <= hold_flag(err_pend, err_set, rd_clr);
      seen_tx   <= hold_flag(seen_tx, ev_tx, rd_clr);
      seen_rx   <= hold_flag(seen_rx, ev_rx, rd_clr);
      seen_err  <= hold_flag(seen_err, ev_err, rd_clr);
    end
  end

  assign rd_val = {boff, ewarn, 1'b0, seen_err, seen_rx, seen_tx,
                   err_pend, stat_pend};

endmodule

// File: rtl/can_irq_objpend.sv
module can_irq_objpend
  import can_irq_pkg::*;
#(
  parameter int NOBJ = 4,
  localparam int IDW = $clog2(NOBJ + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NOBJ-1:0]  tx_done,
  input  logic [NOBJ-1:0]  txie,
  input  logic             clr_en,
  input  logic [REG_W-1:0] clr_id,
  output logic [NOBJ-1:0]  pend,
  output logic             any_pend,
  output logic [REG_W-1:0] rd_val
);

  logic [NOBJ-1:0] set_hit, clr_hit;
  logic [IDW-1:0]  first;

  function automatic logic [IDW-1:0] lowest_id(input logic [NOBJ-1:0] p);
    logic [IDW-1:0] r;
    r = '0;
    for (int k = NOBJ - 1; k >= 0; k--) begin
      if (p[k]) r = IDW'(k + 1);
    end
    return r;
  endfunction

  for (genvar i = 0; i < NOBJ; i++) begin : g_obj
    assign set_hit[i] = tx_done[i] & txie[i];
    assign clr_hit[i] = clr_en && (clr_id == REG_W'(i + 1));

    always_ff @(posedge clk) begin
      if (!rst_n) pend[i] <= 1'b0;
      else        pend[i] <= hold_flag(pend[i], set_hit[i], clr_hit[i]);
    end
  end

  assign any_pend = |pend;
  assign first    = lowest_id(pend);
  assign rd_val   = REG_W'(first);

endmodule

// File: rtl/can_irq_req.sv
module can_irq_req
  import can_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mie,
  input  logic stat_pend,
  input  logic err_pend,
  input  logic obj_any,
  output logic irq
);

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= req_merge(mie, stat_pend, err_pend, obj_any);
  end

endmodule

// File: rtl/can_irq_ctrl.sv
module can_irq_ctrl
  import can_irq_pkg::*;
#(
  parameter int NOBJ = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [1:0]       reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             ev_tx_ok,
  input  logic             ev_rx_ok,
  input  logic             ev_bus_err,
  input  logic             st_boff,
  input  logic             st_ewarn,
  input  logic [NOBJ-1:0]  obj_tx_done,
  input  logic [NOBJ-1:0]  obj_txie,
  output logic             irq_o
);

  ctl_t             ctl_q;
  logic             ctl_mie, ctl_sie, ctl_eie;
  logic             ctl_wr, obj_wr, stat_rd;
  logic             stat_pend, err_pend, obj_any;
  logic             boff_chg, ewarn_chg;
  logic [NOBJ-1:0]  obj_pend;
  logic [REG_W-1:0] ctl_rd, stat_rdv, obj_rd;

  // access decode
  assign ctl_wr  = reg_wr && (reg_sel == SEL_CTRL);
  assign obj_wr  = reg_wr && (reg_sel == SEL_OBJ);
  assign stat_rd = reg_rd && (reg_sel == SEL_STAT);

  can_irq_ctlreg u_ctl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (ctl_wr),
    .wbits  (reg_wdata[3:1]),
    .ctl_o  (ctl_q),
    .rd_val (ctl_rd)
  );

  assign ctl_mie = ctl_q.mie;
  assign ctl_sie = ctl_q.sie;
  assign ctl_eie = ctl_q.eie;

  can_irq_evtrk u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .sie       (ctl_sie),
    .eie       (ctl_eie),
    .ev_tx     (ev_tx_ok),
    .ev_rx     (ev_rx_ok),
    .ev_err    (ev_bus_err),
    .boff      (st_boff),
    .ewarn     (st_ewarn),
    .rd_clr    (stat_rd),
    .stat_pend (stat_pend),
    .err_pend  (err_pend),
    .boff_chg  (boff_chg),
    .ewarn_chg (ewarn_chg),
    .rd_val    (stat_rdv)
  );

  can_irq_objpend #(.NOBJ(NOBJ)) u_obj (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_done  (obj_tx_done),
    .txie     (obj_txie),
    .clr_en   (obj_wr),
    .clr_id   (reg_wdata),
    .pend     (obj_pend),
    .any_pend (obj_any),
    .rd_val   (obj_rd)
  );

  can_irq_req u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .mie       (ctl_mie),
    .stat_pend (stat_pend),
    .err_pend  (err_pend),
    .obj_any   (obj_any),
    .irq       (irq_o)
  );

  // read mux
  always_comb begin
    case (reg_sel)
      SEL_CTRL: reg_rdata = ctl_rd;
      SEL_STAT: reg_rdata = stat_rdv;
      SEL_OBJ:  reg_rdata = obj_rd;
      default:  reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/can_irq_chk.sv
module can_irq_chk #(
  parameter int NOBJ = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ctl_mie,
  input logic            ctl_sie,
  input logic            ctl_eie,
  input logic            ev_tx_ok,
  input logic            ev_rx_ok,
  input logic            ev_bus_err,
  input logic            boff_chg,
  input logic            ewarn_chg,
  input logic            stat_rd,
  input logic            stat_pend,
  input logic            err_pend,
  input logic [NOBJ-1:0] obj_pend,
  input logic [NOBJ-1:0] obj_tx_done,
  input logic [NOBJ-1:0] obj_txie,
  input logic            irq_o
);

  // R8
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_mie |=> !irq_o);

  // R8
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_mie && (stat_pend || err_pend || (|obj_pend))) |=> irq_o);

  // R3
  stat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_sie && (ev_tx_ok || ev_rx_ok || ev_bus_err)) |=> stat_pend);

  // R3
  stat_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_sie && !stat_pend) |=> !stat_pend);

  // R4
  err_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_eie && (boff_chg || ewarn_chg)) |=> err_pend);

  // R4
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_eie && !err_pend) |=> !err_pend);

  // R5
  stat_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !ctl_sie) |=> !stat_pend);

  for (genvar i = 0; i < NOBJ; i++) begin : g_chk
    // R6
    obj_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (obj_tx_done[i] && obj_txie[i]) |=> obj_pend[i]);

    // R6
    obj_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!obj_pend[i] && !(obj_tx_done[i] && obj_txie[i])) |=> !obj_pend[i]);
  end

endmodule

bind can_irq_ctrl can_irq_chk #(.NOBJ(NOBJ)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ctl_mie     (ctl_mie),
  .ctl_sie     (ctl_sie),
  .ctl_eie     (ctl_eie),
  .ev_tx_ok    (ev_tx_ok),
  .ev_rx_ok    (ev_rx_ok),
  .ev_bus_err  (ev_bus_err),
  .boff_chg    (boff_chg),
  .ewarn_chg   (ewarn_chg),
  .stat_rd     (stat_rd),
  .stat_pend   (stat_pend),
  .err_pend    (err_pend),
  .obj_pend    (obj_pend),
  .obj_tx_done (obj_tx_done),
  .obj_txie    (obj_txie),
  .irq_o       (irq_o)
);

// File: tb/sim_can_irq_ctrl.sv
`timescale 1ns/1ps
module sim_can_irq_ctrl;

  localparam int NOBJ = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]      reg_sel = 2'd0;
  logic [7:0]      reg_wdata = 8'd0;
  logic [7:0]      reg_rdata;
  logic            ev_tx_ok = 1'b0, ev_rx_ok = 1'b0, ev_bus_err = 1'b0;
  logic            st_boff = 1'b0, st_ewarn = 1'b0;
  logic [NOBJ-1:0] obj_tx_done = '0;
  logic [NOBJ-1:0] obj_txie = '0;
  logic            irq_o;

  int errs = 0;
  int checks = 0;

  always #4 clk = ~clk;

  can_irq_ctrl #(.NOBJ(NOBJ)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_tx_ok(ev_tx_ok), .ev_rx_ok(ev_rx_ok), .ev_bus_err(ev_bus_err),
    .st_boff(st_boff), .st_ewarn(st_ewarn), .obj_tx_done(obj_tx_done),
    .obj_txie(obj_txie), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] d);
    reg_sel = s; reg_rd = 1'b1;
    #1;
    d = reg_rdata;
    tick();
    reg_rd = 1'b0;
  endtask

  task automatic obj_done(input logic [NOBJ-1:0] m);
    obj_tx_done = m;
    tick();
    obj_tx_done = '0;
  endtask

  initial begin : watchdog
    #(8 * 100000);
    errs++;
    checks++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    repeat (4) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 irq", {7'd0, irq_o}, 8'd0);
    rd(2'd0, v); chk("R1 ctrl", v, 8'h00);
    rd(2'd1, v); chk("R1 status", v, 8'h00);
    rd(2'd2, v); chk("R1 obj", v, 8'h00);

    // R2 control sweep
    for (int d = 0; d < 256; d++) begin
      wr(2'd0, 8'(d));
      rd(2'd0, v);
      chk("R2 ctrl", v, 8'(d) & 8'h0E);
    end
    wr(2'd0, 8'h00);

    // R9 unused select
    wr(2'd3, 8'hFF);
    rd(2'd3, v); chk("R9 sel3", v, 8'h00);
    rd(2'd0, v); chk("R9 ctrl untouched", v, 8'h00);

    // R3 / R5 status-change events
    for (int s = 0; s < 2; s++) begin
      for (int e = 0; e < 3; e++) begin
        wr(2'd0, 8'(s << 2));
        ev_tx_ok = (e == 0); ev_rx_ok = (e == 1); ev_bus_err = (e == 2);
        tick();
        ev_tx_ok = 1'b0; ev_rx_ok = 1'b0; ev_bus_err = 1'b0;
        rd(2'd1, v);
        chk("R3 stat pend", v, 8'(s) | 8'(1 << (2 + e)));
        rd(2'd1, v);
        chk("R5 read clears", v, 8'h00);
        chk("R8 irq masked", {7'd0, irq_o}, 8'd0);
      end
    end

    // R4 / R5 bus-off and warning edges
    for (int en = 0; en < 2; en++) begin
      for (int w = 0; w < 2; w++) begin
        for (int lv = 1; lv >= 0; lv--) begin
          logic [7:0] lvl_bits;
          wr(2'd0, 8'(en << 3));
          if (w == 0) st_boff = lv[0]; else st_ewarn = lv[0];
          tick();
          lvl_bits = (lv == 0) ? 8'h00 : ((w == 0) ? 8'h80 : 8'h40);
          rd(2'd1, v);
          chk("R4 err on edge", v, lvl_bits | ((en != 0) ? 8'h02 : 8'h00));
          rd(2'd1, v);
          chk("R4 steady level", v, lvl_bits);
        end
      end
    end

    // R5 event in the same cycle as a status read
    wr(2'd0, 8'h04);
    reg_sel = 2'd1; reg_rd = 1'b1; ev_rx_ok = 1'b1;
    #1; v = reg_rdata;
    tick();
    reg_rd = 1'b0; ev_rx_ok = 1'b0;
    chk("R5 pre-read value", v, 8'h00);
    rd(2'd1, v); chk("R5 set wins", v, 8'h09);

    // R6 / R7 per-object set with and without enable
    wr(2'd0, 8'h00);
    for (int i = 0; i < NOBJ; i++) begin
      for (int en = 0; en < 2; en++) begin
        obj_txie = (en != 0) ? NOBJ'(1 << i) : '0;
        obj_done(NOBJ'(1 << i));
        rd(2'd2, v);
        chk("R6 obj set", v, (en != 0) ? 8'(i + 1) : 8'h00);
        wr(2'd2, 8'(i + 1));
        rd(2'd2, v);
        chk("R6 obj clear", v, 8'h00);
      end
    end

    // R7 lowest first, R6 invalid codes ignored
    obj_txie = '1;
    obj_done('1);
    for (int d = 0; d < 256; d++) begin
      if (d == 0 || d > NOBJ) wr(2'd2, 8'(d));
    end
    rd(2'd2, v); chk("R6 bad codes ignored", v, 8'h01);
    for (int i = 0; i < NOBJ; i++) begin
      rd(2'd2, v); chk("R7 lowest id", v, 8'(i + 1));
      wr(2'd2, 8'(i + 1));
    end
    rd(2'd2, v); chk("R7 none", v, 8'h00);

    // R6 same-cycle set and clear
    obj_done(NOBJ'(1));
    reg_sel = 2'd2; reg_wdata = 8'h01; reg_wr = 1'b1; obj_tx_done = NOBJ'(1);
    tick();
    reg_wr = 1'b0; obj_tx_done = '0;
    rd(2'd2, v); chk("R6 set wins", v, 8'h01);
    wr(2'd2, 8'h01);

    // R8 interrupt timing
    wr(2'd0, 8'h06);
    tick();
    chk("R8 idle", {7'd0, irq_o}, 8'd0);
    ev_tx_ok = 1'b1;
    tick();
    ev_tx_ok = 1'b0;
    chk("R8 one edge late", {7'd0, irq_o}, 8'd0);
    tick();
    chk("R8 raised", {7'd0, irq_o}, 8'd1);
    obj_done(NOBJ'(4));
    rd(2'd1, v);
    tick();
    chk("R8 held by object", {7'd0, irq_o}, 8'd1);
    wr(2'd2, 8'h03);
    tick();
    chk("R8 all cleared", {7'd0, irq_o}, 8'd0);

    obj_done(NOBJ'(1));
    tick();
    chk("R8 obj raise", {7'd0, irq_o}, 8'd1);
    wr(2'd0, 8'h04);
    tick();
    chk("R8 master off", {7'd0, irq_o}, 8'd0);
    rd(2'd2, v); chk("R8 pend kept", v, 8'h01);
    wr(2'd0, 8'h06);
    tick();
    chk("R8 master on", {7'd0, irq_o}, 8'd1);
    wr(2'd2, 8'h01);
    tick();

    // R8 via error pending
    wr(2'd0, 8'h0A);
    st_ewarn = 1'b1;
    tick();
    tick();
    chk("R8 err raise", {7'd0, irq_o}, 8'd1);
    rd(2'd1, v); chk("R4 warn status", v, 8'h42);
    tick();
    chk("R8 err cleared", {7'd0, irq_o}, 8'd0);
    st_ewarn = 1'b0;
    tick();

    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule